// File: doc/BRIEF.md
# Byte-Oriented Synchronous Receive Framer

This block takes a serial bit stream whose bit cells are marked by a clock shared with the far-end transmitter. A one-cycle `bit_en` qualifier marks each bit, so the block does no oversampling. Before alignment is known, the incoming bits have no fixed relation to character boundaries. The framer starts in a hunt state and finds the boundary by one of three methods, chosen by `mode`:

- match one programmed sync byte (monosync);
- match two programmed sync bytes in sequence (bisync);
- take the boundary from an external strobe that is high while the first character bit is presented.

Once aligned, the framer assembles characters of 5 to 8 bits back to back and presents each one with a single-cycle valid strobe. It keeps doing so until software issues an enter-hunt command. CRC checking and sync-character stripping belong to later stages.

Top module: `sync_rx_framer`

## Requirements
- R1: While `rst_n` is low and at its release, `sync_ok`, `char_vld` and `char_out` are all zero.
- R2: While `sync_ok` is low, `char_vld` never goes high and no character is produced.
- R3: With `mode`=0 (monosync), `sync_ok` goes high right after the clock edge that samples the bit completing a match of the last 8 bits against `sync_a`. Bits arrive most significant first. A match needs at least 8 bits accepted since the last hunt or reset, because the window is cleared on hunt.
- R4: With `mode`=1 (bisync), alignment needs the last 16 bits to equal `sync_a` followed by `sync_b`, with both bytes sent MSB first. A match of either byte alone does not set `sync_ok`.
- R5: With `mode`=2 or 3 (external), a bit sampled with `bit_en` and `ext_sync` both high during hunt is the first bit of the first character. `sync_ok` goes high after that edge.
- R6: A character has 5+`char_len` bits (`char_len` 0..3). Its first received bit lands at position `char_len`+4 of `char_out`, and the unused upper bits are zero. Characters follow the sync boundary back to back.
- R7: `char_vld` is high for exactly one clock cycle, right after the edge that samples a character's last bit, and `char_out` holds the character at that time.
- R8: `sync_ok` stays high until `hunt_cmd`. A `hunt_cmd` wins over everything else: it clears `sync_ok` and any partial character, discards the bit presented in that cycle, and returns the block to hunt.
- R9: Only cycles with `bit_en` high advance the framer. Changes on `rx_bit` or `ext_sync` while `bit_en` is low have no effect.
- R10: `ext_sync` is ignored in modes 0 and 1, and in every mode once `sync_ok` is high, so it never re-aligns a running stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks the cycle in which `rx_bit` carries a new bit |
| rx_bit | input | 1 | Serial receive data |
| mode | input | 2 | 0 monosync, 1 bisync, 2/3 external strobe |
| char_len | input | 2 | Character length minus 5 |
| sync_a | input | SYNC_W | Monosync pattern, or first bisync byte |
| sync_b | input | SYNC_W | Second bisync byte |
| ext_sync | input | 1 | External alignment strobe |
| hunt_cmd | input | 1 | Enter-hunt command |
| char_out | output | CHAR_W | Last assembled character, right-justified |
| char_vld | output | 1 | One-cycle strobe for a new character |
| sync_ok | output | 1 | Alignment acquired |

## Verification
The embedded properties watch every cycle for these rules:
- a strobe never shows up during hunt;
- the strobe never lasts more than one cycle;
- `sync_ok` only rises on an accepted bit and is sticky until a hunt command, which always clears it;
- the assembler's bit count stays within a character.

Only the bench scenarios can show that the boundary lands exactly after the sync pattern or at the external strobe, that characters carry the right value for each length, that a lone bisync byte or a window that is not yet full cannot match, and that idle cycles and late strobes leave alignment untouched.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic [1:0] {
    MODE_MONO = 2'd0,
    MODE_BI   = 2'd1,
    MODE_EXT  = 2'd2,
    MODE_EXT2 = 2'd3
  } sync_mode_e;

  // number of bits in one character for a length select value
  function automatic int unsigned char_bits(input int unsigned min_bits,
                                            input logic [1:0] sel);
    return min_bits + int'(sel);
  endfunction

  // saturating increment of a fill level
  function automatic int unsigned sat_inc(input int unsigned val,
                                          input int unsigned limit);
    return (val >= limit) ? limit : val + 1;
  endfunction

  function automatic logic is_ext_mode(input sync_mode_e m);
    return (m == MODE_EXT) || (m == MODE_EXT2);
  endfunction

endpackage

// File: rtl/sync_shift_window.sv
module sync_shift_window #(
  parameter int unsigned SYNC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     shift,
  input  logic                     din,
  output logic [2*SYNC_W-1:0]      next_win,
  output logic [$clog2(2*SYNC_W+1)-1:0] next_fill
);
  localparam int unsigned WIN_W  = 2 * SYNC_W;
  localparam int unsigned FILL_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q;

  // window as it would look with the current bit appended
  assign next_win  = {win_q[WIN_W-2:0], din};
  assign next_fill = FILL_W'(sync_rx_pkg::sat_inc(int'(fill_q), WIN_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift) begin
      win_q  <= next_win;
      fill_q <= next_fill;
    end
  end

  // window fill never exceeds its width (R3 depends on it)
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(WIN_W));

  // a cleared window restarts empty (R3)
  p_clr_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0));

endmodule

// File: rtl/sync_hunt_detect.sv
module sync_hunt_detect #(
  parameter int unsigned SYNC_W = 8
) (
  input  sync_rx_pkg::sync_mode_e       mode,
  input  logic [SYNC_W-1:0]             pat_a,
  input  logic [SYNC_W-1:0]             pat_b,
  input  logic [2*SYNC_W-1:0]           next_win,
  input  logic [$clog2(2*SYNC_W+1)-1:0] next_fill,
  input  logic                          take,
  input  logic                          ext_sync,
  output logic                          acquire,
  output logic                          ext_start
);
  localparam int unsigned WIN_W  = 2 * SYNC_W;
  localparam int unsigned FILL_W = $clog2(WIN_W + 1);

  logic mono_hit;
  logic bi_hit;
  logic ext_hit;

  assign mono_hit = (mode == sync_rx_pkg::MODE_MONO) &&
                    (next_fill >= FILL_W'(SYNC_W)) &&
                    (next_win[SYNC_W-1:0] == pat_a);

  assign bi_hit   = (mode == sync_rx_pkg::MODE_BI) &&
                    (next_fill >= FILL_W'(WIN_W)) &&
                    (next_win == {pat_a, pat_b});

  assign ext_hit  = sync_rx_pkg::is_ext_mode(mode) && ext_sync;

  assign acquire   = take && (mono_hit || bi_hit || ext_hit);
  assign ext_start = take && ext_hit;

endmodule

// File: rtl/sync_char_asm.sv
module sync_char_asm #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              shift,
  input  logic              din,
  input  logic [1:0]        len_sel,
  output logic [CHAR_W-1:0] char_q,
  output logic              vld_q
);
  localparam int unsigned MIN_BITS = CHAR_W - 3;
  localparam int unsigned CNT_W    = $clog2(CHAR_W + 1);

  logic [CHAR_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  nbits;
  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] acc_next;
  logic              last_bit;

  assign nbits    = CNT_W'(sync_rx_pkg::char_bits(MIN_BITS, len_sel));
  assign cnt_inc  = cnt_q + 1'b1;
  assign acc_next = {acc_q[CHAR_W-2:0], din};
  assign last_bit = shift && (cnt_inc >= nbits);

  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < nbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      char_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start) begin
        acc_q <= {{(CHAR_W-1){1'b0}}, din};
        cnt_q <= CNT_W'(1);
      end else if (last_bit) begin
        char_q <= acc_next & mask;
        vld_q  <= 1'b1;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (shift) begin
        acc_q <= acc_next;
        cnt_q <= cnt_inc;
      end
    end
  end

  // strobe is a single cycle (R7)
  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // a strobe always follows an accepted bit (R9)
  p_vld_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(shift));

  // bit count stays inside one character (R6)
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CHAR_W));

endmodule

// File: rtl/sync_rx_framer.sv
module sync_rx_framer #(
  parameter int unsigned SYNC_W = 8,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [1:0]        mode,
  input  logic [1:0]        char_len,
  input  logic [SYNC_W-1:0] sync_a,
  input  logic [SYNC_W-1:0] sync_b,
  input  logic              ext_sync,
  input  logic              hunt_cmd,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_vld,
  output logic              sync_ok
);
  localparam int unsigned WIN_W  = 2 * SYNC_W;
  localparam int unsigned FILL_W = $clog2(WIN_W + 1);

  sync_rx_pkg::sync_mode_e md;
  logic                    sync_q;
  logic                    take;
  logic                    hunt_take;
  logic                    run_take;
  logic [WIN_W-1:0]        next_win;
  logic [FILL_W-1:0]       next_fill;
  logic                    acquire;
  logic                    ext_start;

  assign md        = sync_rx_pkg::sync_mode_e'(mode);
  assign take      = bit_en && !hunt_cmd;
  assign hunt_take = take && !sync_q;
  assign run_take  = take && sync_q;

  sync_shift_window #(.SYNC_W(SYNC_W)) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hunt_cmd),
    .shift     (hunt_take),
    .din       (rx_bit),
    .next_win  (next_win),
    .next_fill (next_fill)
  );

  sync_hunt_detect #(.SYNC_W(SYNC_W)) det_i (
    .mode      (md),
    .pat_a     (sync_a),
    .pat_b     (sync_b),
    .next_win  (next_win),
    .next_fill (next_fill),
    .take      (hunt_take),
    .ext_sync  (ext_sync),
    .acquire   (acquire),
    .ext_start (ext_start)
  );

  sync_char_asm #(.CHAR_W(CHAR_W)) asm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hunt_cmd),
    .start   (ext_start),
    .shift   (run_take),
    .din     (rx_bit),
    .len_sel (char_len),
    .char_q  (char_out),
    .vld_q   (char_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_q <= 1'b0;
    else if (hunt_cmd) sync_q <= 1'b0;
    else if (acquire)  sync_q <= 1'b1;
  end

  assign sync_ok = sync_q;

  // no character while hunting (R2)
  p_no_char_in_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> sync_ok);

  // hunt command always drops alignment (R8)
  p_hunt_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> !sync_ok);

  // alignment is sticky without a hunt command (R8)
  p_sync_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !hunt_cmd) |=> sync_ok);

  // alignment only rises on an accepted bit (R9)
  p_rise_on_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(bit_en && !hunt_cmd));

endmodule

// File: tb/sync_rx_framer_tb_top.sv
module sync_rx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] sync_a = 8'h00;
  logic [7:0] sync_b = 8'h00;
  logic       ext_sync = 1'b0;
  logic       hunt_cmd = 1'b0;
  logic [7:0] char_out;
  logic       char_vld;
  logic       sync_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int vld_seen = 0;

  always #10 clk = ~clk;

  sync_rx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .mode(mode), .char_len(char_len), .sync_a(sync_a), .sync_b(sync_b),
    .ext_sync(ext_sync), .hunt_cmd(hunt_cmd),
    .char_out(char_out), .char_vld(char_vld), .sync_ok(sync_ok)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [1:0] len;
    logic [7:0] sa;
    logic [7:0] sb;
    logic [3:0] lead_n;
    logic [7:0] lead;
    logic [7:0] c0;
    logic [7:0] c1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{md:2'd0, len:2'd3, sa:8'h16, sb:8'h00, lead_n:4'd3, lead:8'h05, c0:8'hA5, c1:8'h3C},
    '{md:2'd0, len:2'd0, sa:8'h7E, sb:8'h00, lead_n:4'd0, lead:8'h00, c0:8'h13, c1:8'h0A},
    '{md:2'd1, len:2'd3, sa:8'hEB, sb:8'h90, lead_n:4'd2, lead:8'h01, c0:8'h55, c1:8'hC3},
    '{md:2'd1, len:2'd2, sa:8'h32, sb:8'h32, lead_n:4'd0, lead:8'h00, c0:8'h7F, c1:8'h01},
    '{md:2'd2, len:2'd3, sa:8'h00, sb:8'h00, lead_n:4'd5, lead:8'h1A, c0:8'hF0, c1:8'h0F},
    '{md:2'd3, len:2'd1, sa:8'h00, sb:8'h00, lead_n:4'd4, lead:8'h09, c0:8'h2A, c1:8'h15}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one accepted bit; outputs sampled at the following falling edge
  task automatic send_bit(input logic b, input logic e);
    rx_bit = b; ext_sync = e; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; ext_sync = 1'b0;
    if (char_vld) vld_seen++;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hunt();
    hunt_cmd = 1'b1;
    @(negedge clk);
    hunt_cmd = 1'b0;
  endtask

  // sends one character MSB first; checks strobe only on the last bit and value
  task automatic send_char(input logic [7:0] v, input int n, input logic ext_first,
                           input int gap, input string req);
    int early;
    logic [7:0] expv;
    early = 0;
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(v[i], (i == n - 1) ? ext_first : 1'b0);
      if (i != 0) begin
        if (char_vld) early++;
        for (int g = 0; g < gap; g++) begin
          rx_bit = ~rx_bit; ext_sync = ~ext_sync;
          @(negedge clk);
          if (char_vld) early++;
        end
        ext_sync = 1'b0;
      end
    end
    expv = v & 8'((1 << n) - 1);
    chk(char_vld == 1'b1 && early == 0, req, "strobe at last bit only",
        int'(char_vld) + 2 * early, 1);
    chk(char_out == expv, req, "char value", int'(char_out), int'(expv));
    @(negedge clk);
    chk(char_vld == 1'b0, "R7", "strobe one cycle", int'(char_vld), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(sync_ok == 0 && char_vld == 0 && char_out == 0, "R1", "reset state",
        {sync_ok, char_vld, char_out}, 0);
    rst_n = 1'b1;
    idle(1);
    chk(sync_ok == 0 && char_vld == 0 && char_out == 0, "R1", "after release",
        {sync_ok, char_vld, char_out}, 0);

    // table of scenarios
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      int n;
      bit ext;
      v = VECS[k];
      mode = v.md; char_len = v.len; sync_a = v.sa; sync_b = v.sb;
      n = 5 + int'(v.len);
      ext = v.md[1];
      hunt();
      vld_seen = 0;
      for (int i = int'(v.lead_n) - 1; i >= 0; i--) send_bit(v.lead[i], 1'b0);
      if (!ext) begin
        logic [15:0] pat;
        int plen;
        plen = (v.md == 2'd1) ? 16 : 8;
        pat  = (v.md == 2'd1) ? {v.sa, v.sb} : {v.sa, 8'h00};
        for (int i = 15; i > 16 - plen; i--) send_bit(pat[i], 1'b0);
        chk(sync_ok == 0, (v.md == 2'd1) ? "R4" : "R3", "no sync before last bit",
            int'(sync_ok), 0);
        send_bit(pat[16 - plen], 1'b0);
        chk(sync_ok == 1, (v.md == 2'd1) ? "R4" : "R3", "sync after pattern",
            int'(sync_ok), 1);
        chk(vld_seen == 0, "R2", "no char in hunt", vld_seen, 0);
        send_char(v.c0, n, 1'b0, 0, "R6");
      end else begin
        chk(sync_ok == 0, "R5", "hunt before strobe", int'(sync_ok), 0);
        chk(vld_seen == 0, "R2", "no char in hunt", vld_seen, 0);
        send_char(v.c0, n, 1'b1, 0, "R5");
      end
      send_char(v.c1, n, 1'b0, 0, "R6");
    end

    // R3: window must hold 8 bits after hunt before a match counts
    mode = 2'd0; sync_a = 8'h00; char_len = 2'd3;
    hunt();
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0);
    chk(sync_ok == 0, "R3", "7 bits cannot match", int'(sync_ok), 0);
    send_bit(1'b0, 1'b0);
    chk(sync_ok == 1, "R3", "8th bit matches", int'(sync_ok), 1);

    // R8: hunt with a bit present drops sync and partial char
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    hunt_cmd = 1'b1; bit_en = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    hunt_cmd = 1'b0; bit_en = 1'b0;
    chk(sync_ok == 0 && char_vld == 0, "R8", "hunt clears", {sync_ok, char_vld}, 0);
    idle(2);
    chk(sync_ok == 0, "R8", "stays in hunt", int'(sync_ok), 0);

    // R4: only the second byte present does not align
    mode = 2'd1; sync_a = 8'hA1; sync_b = 8'h5C;
    hunt();
    send_byte(8'h00); send_byte(8'h5C);
    chk(sync_ok == 0, "R4", "lone second byte", int'(sync_ok), 0);
    send_byte(8'hA1);
    chk(sync_ok == 0, "R4", "lone first byte", int'(sync_ok), 0);
    send_byte(8'h5C);
    chk(sync_ok == 1, "R4", "both bytes", int'(sync_ok), 1);

    // R10: ext strobe ignored in monosync mode
    mode = 2'd0; sync_a = 8'hFF;
    hunt();
    send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
    chk(sync_ok == 0, "R10", "strobe ignored in mono", int'(sync_ok), 0);

    // R9: ext strobe without bit_en does nothing
    mode = 2'd2; char_len = 2'd3;
    hunt();
    ext_sync = 1'b1; rx_bit = 1'b1;
    idle(3);
    ext_sync = 1'b0;
    chk(sync_ok == 0, "R9", "strobe without bit_en", int'(sync_ok), 0);

    // R9 + R10: idle cycles with toggling inputs and late strobes keep alignment
    send_char(8'h96, 8, 1'b1, 2, "R9");
    send_char(8'h4D, 8, 1'b0, 2, "R10");
    chk(sync_ok == 1, "R8", "sync sticky", int'(sync_ok), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule